// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out, for every pin of a general-purpose I/O bank, the level the pin actually settles at. Each pin can be driven by the bank's own output stage, by something outside the chip, by a weak pull resistor, or by nothing. The output stage takes its level from the output data bit, optionally inverted by a per-pin polarity bit. It drives only when the pin's output enable is set. A per-pin open-drain bit further restricts it to driving low.

The block combines the drivers and reports the resulting level on each pin. It also raises a per-pin flag when the level cannot be trusted: either the two drivers fight, or nothing drives the pin and no pull is enabled. The input data vector is formed by masking the resolved level with the per-pin input enable and then applying the same polarity inversion. This vector is registered once per clock, so event logic downstream sees clean, glitch-free transitions.

Each pin is sorted into one of six resolution cases: external only, internal only, shared, pulled up, pulled down, and floating. The case picks the level and the undefined flag for that pin. The resolved level and the flag are combinational. The input data vector follows the inputs one clock later.

Top module: `gpio_pin_resolver`

## Requirements
- R1: The internal drive level of a pin is its output-data bit XOR its polarity bit. With output enable set and open-drain clear, the pin is driven internally at that level.
- R2: With the open-drain bit set, a pin whose internal drive level is 1 is not driven internally. A pin whose internal drive level is 0 is driven low only when its output enable is set.
- R3: A pin driven internally and externally at opposite levels has its undefined flag set, and its resolved level reads 1.
- R4: On a driven pin, the resolved level is the external level (where driven externally) ORed with the internal level (where driven internally). The undefined flag is clear when the two drivers agree.
- R5: A pin driven by neither side resolves to 1 when its pull-up is enabled, whether or not its pull-down is enabled. The undefined flag is clear.
- R6: A pin driven by neither side, with pull-down enabled and pull-up disabled, resolves to 0 with the undefined flag clear.
- R7: A pin driven by neither side, with neither pull enabled, resolves to 0 with the undefined flag set.
- R8: Data-in equals (resolved level AND input enable) XOR polarity, sampled at every rising clock edge. It follows any change of the configuration or external inputs after exactly one clock.
- R9: While reset is asserted (active low, asynchronous), data-in is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the data-in register |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_data | input | PINS | Output data bit per pin |
| polarity | input | PINS | Per-pin inversion of output and input data |
| out_en | input | PINS | Per-pin output enable |
| open_drain | input | PINS | Per-pin open-drain mode (drive low only) |
| pull_up | input | PINS | Per-pin pull-up enable |
| pull_dn | input | PINS | Per-pin pull-down enable |
| in_en | input | PINS | Per-pin input enable mask for data-in |
| ext_drive | input | PINS | Pin driven from outside |
| ext_level | input | PINS | Level applied from outside where driven |
| pin_level | output | PINS | Resolved pin level |
| pin_undef | output | PINS | Per-pin undefined flag (contention or floating) |
| data_in | output | PINS | Registered input data after masking and polarity |

## Verification
The bench builds the block at its default width of 32 pins. This gives a full bank in which different bit patterns can put every resolution case on different pins in the same cycle. Directed phases place alternating, nibble and byte patterns across polarity, open-drain, pull and external-drive masks. This covers contention, open-drain high with each pull choice, and floating pins. A long run of random vectors then checks mixed cases, such as pull-up and pull-down both enabled and polarity applied to masked inputs, against a behavioural per-pin model on every clock. The same run checks the one-cycle lag of data-in.

// File: rtl/gres_pkg.sv
package gres_pkg;

    // Resolution case of one pin
    typedef enum logic [2:0] {
        SRC_EXT     = 3'd0,
        SRC_INT     = 3'd1,
        SRC_SHARED  = 3'd2,
        SRC_PULL_UP = 3'd3,
        SRC_PULL_DN = 3'd4,
        SRC_FLOAT   = 3'd5
    } pin_src_e;

    function automatic pin_src_e classify(input logic int_en, input logic ext_en,
                                          input logic pu, input logic pd);
        pin_src_e s;
        if (int_en && ext_en)      s = SRC_SHARED;
        else if (int_en)           s = SRC_INT;
        else if (ext_en)           s = SRC_EXT;
        else if (pu)               s = SRC_PULL_UP;
        else if (pd)               s = SRC_PULL_DN;
        else                       s = SRC_FLOAT;
        return s;
    endfunction

endpackage

// File: rtl/gres_drive.sv
module gres_drive #(
    parameter int PINS = 32
) (
    input  logic [PINS-1:0] out_data,
    input  logic [PINS-1:0] polarity,
    input  logic [PINS-1:0] out_en,
    input  logic [PINS-1:0] open_drain,
    output logic [PINS-1:0] drv_level,
    output logic [PINS-1:0] drv_en
);

    always_comb begin
        drv_level = out_data ^ polarity;
        // open-drain pins release the line when the level would be high
        drv_en    = out_en & ~(open_drain & drv_level);
    end

endmodule

// File: rtl/gres_merge.sv
module gres_merge
    import gres_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] drv_level,
    input  logic [PINS-1:0] drv_en,
    input  logic [PINS-1:0] ext_drive,
    input  logic [PINS-1:0] ext_level,
    input  logic [PINS-1:0] pull_up,
    input  logic [PINS-1:0] pull_dn,
    output logic [PINS-1:0] pin_level,
    output logic [PINS-1:0] pin_undef
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pin_src_e src;
        always_comb begin
            src = classify(drv_en[i], ext_drive[i], pull_up[i], pull_dn[i]);
            pin_level[i] = 1'b0;
            pin_undef[i] = 1'b0;
            unique case (src)
                SRC_SHARED: begin
                    pin_level[i] = ext_level[i] | drv_level[i];
                    pin_undef[i] = ext_level[i] ^ drv_level[i];
                end
                SRC_INT:     pin_level[i] = drv_level[i];
                SRC_EXT:     pin_level[i] = ext_level[i];
                SRC_PULL_UP: pin_level[i] = 1'b1;
                SRC_PULL_DN: pin_level[i] = 1'b0;
                SRC_FLOAT:   pin_undef[i] = 1'b1;
                default: begin
                    pin_level[i] = 1'b0;
                    pin_undef[i] = 1'b1;
                end
            endcase
        end
    end

    // R3: opposite drivers always flag the pin
    a_r3_contention: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_en & ext_drive & (drv_level ^ ext_level)) & ~pin_undef) == '0);

    // R4: externally driven pin with idle output stage shows the external level
    a_r4_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext_drive & ~drv_en) & (pin_level ^ ext_level)) == '0);

    // R5: undriven pin with pull-up reads high
    a_r5_pull_up: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ext_drive & ~drv_en & pull_up) & ~pin_level) == '0);

    // R7: undriven pin with no pull is flagged
    a_r7_floating: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ext_drive & ~drv_en & ~pull_up & ~pull_dn) & ~pin_undef) == '0);

endmodule

// File: rtl/gres_sample.sv
module gres_sample #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_level,
    input  logic [PINS-1:0] in_en,
    input  logic [PINS-1:0] polarity,
    output logic [PINS-1:0] data_in
);

    logic [PINS-1:0] din_next;

    always_comb din_next = (pin_level & in_en) ^ polarity;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_in <= '0;
        else        data_in <= din_next;
    end

    // R9: reset clears data-in
    a_r9_reset_zero: assert property (@(posedge clk) !rst_n |-> data_in == '0);

    // R8: masked input bits equal polarity one clock later
    a_r8_masked_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((data_in ^ $past(polarity)) & ~$past(in_en)) == '0);

endmodule

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] out_data,
    input  logic [PINS-1:0] polarity,
    input  logic [PINS-1:0] out_en,
    input  logic [PINS-1:0] open_drain,
    input  logic [PINS-1:0] pull_up,
    input  logic [PINS-1:0] pull_dn,
    input  logic [PINS-1:0] in_en,
    input  logic [PINS-1:0] ext_drive,
    input  logic [PINS-1:0] ext_level,
    output logic [PINS-1:0] pin_level,
    output logic [PINS-1:0] pin_undef,
    output logic [PINS-1:0] data_in
);

    logic [PINS-1:0] drv_level;
    logic [PINS-1:0] drv_en;

    gres_drive #(.PINS(PINS)) drive_i (
        .out_data   (out_data),
        .polarity   (polarity),
        .out_en     (out_en),
        .open_drain (open_drain),
        .drv_level  (drv_level),
        .drv_en     (drv_en)
    );

    gres_merge #(.PINS(PINS)) merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_level (drv_level),
        .drv_en    (drv_en),
        .ext_drive (ext_drive),
        .ext_level (ext_level),
        .pull_up   (pull_up),
        .pull_dn   (pull_dn),
        .pin_level (pin_level),
        .pin_undef (pin_undef)
    );

    gres_sample #(.PINS(PINS)) sample_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .in_en     (in_en),
        .polarity  (polarity),
        .data_in   (data_in)
    );

    // R2: open-drain pin asked to go high, with pull-down only and nothing outside, reads low
    a_r2_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((open_drain & out_en & (out_data ^ polarity) & ~ext_drive & pull_dn & ~pull_up)
         & pin_level) == '0);

    // R1: push-pull enabled pin without outside driver follows data XOR polarity
    a_r1_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_en & ~open_drain & ~ext_drive) & (pin_level ^ out_data ^ polarity)) == '0);

    // R8: data-in follows the resolved pins after one clock
    a_r8_din_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> data_in == (($past(pin_level) & $past(in_en)) ^ $past(polarity)));

endmodule

// File: tb/gpio_pin_resolver_tb_top.sv
`timescale 1ns/1ps
module gpio_pin_resolver_tb_top;

    localparam int PINS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PINS-1:0] out_data = '0, polarity = '0, out_en = '0, open_drain = '0;
    logic [PINS-1:0] pull_up = '0, pull_dn = '0, in_en = '0, ext_drive = '0, ext_level = '0;
    logic [PINS-1:0] pin_level, pin_undef, data_in;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R9";
    logic [PINS-1:0] exp_din = '0;

    always #2 clk = ~clk;

    gpio_pin_resolver #(.PINS(PINS)) dut_i (
        .clk(clk), .rst_n(rst_n), .out_data(out_data), .polarity(polarity),
        .out_en(out_en), .open_drain(open_drain), .pull_up(pull_up), .pull_dn(pull_dn),
        .in_en(in_en), .ext_drive(ext_drive), .ext_level(ext_level),
        .pin_level(pin_level), .pin_undef(pin_undef), .data_in(data_in)
    );

    // behavioural per-pin model
    function automatic void model(output logic [PINS-1:0] lv, output logic [PINS-1:0] un);
        for (int i = 0; i < PINS; i++) begin
            bit drv_l, drv_on, free;
            drv_l  = out_data[i] ^ polarity[i];
            drv_on = out_en[i] && !(open_drain[i] && drv_l);
            free   = !drv_on && !ext_drive[i];
            lv[i]  = (ext_drive[i] && ext_level[i]) || (drv_on && drv_l) || (free && pull_up[i]);
            un[i]  = (drv_on && ext_drive[i] && (drv_l != ext_level[i]))
                  || (free && !pull_up[i] && !pull_dn[i]);
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic [PINS-1:0] lv, un;
        if (!rst_n) exp_din <= '0;
        else begin
            model(lv, un);
            exp_din <= (lv & in_en) ^ polarity;
        end
    end

    task automatic check(string what, logic [PINS-1:0] act, logic [PINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic [PINS-1:0] lv, un;
        cycles++;
        if (!rst_n) check("data_in during reset", data_in, '0);
        else begin
            model(lv, un);
            check("pin_level", pin_level, lv);
            check("pin_undef", pin_undef, un);
            check("data_in", data_in, exp_din);
        end
    end

    task automatic hold(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
        finish_run();
    end

    initial begin
        tag = "R9";
        hold(3);
        rst_n = 1'b1;
        hold(1);

        tag = "R1"; // push-pull, polarity applied
        out_en = '1; out_data = 32'hA5A5_0FF0; polarity = 32'h00FF_FF00; in_en = '1;
        hold(3);

        tag = "R2"; // open-drain, pull-down: everything low
        open_drain = '1; polarity = '0; pull_dn = '1;
        hold(3);
        tag = "R2"; // open-drain with pull-up: released pins go high
        pull_up = '1; pull_dn = '0;
        hold(3);

        tag = "R3"; // contention on every pin
        open_drain = '0; pull_up = '0; ext_drive = '1; ext_level = ~(out_data ^ polarity);
        hold(3);

        tag = "R4"; // agreement and external-only pins
        ext_level = out_data ^ polarity;
        hold(2);
        out_en = 32'h0000_FFFF; ext_drive = 32'h00FF_00FF; ext_level = 32'h3C3C_C3C3;
        pull_dn = 32'hFF00_0000;
        hold(3);

        tag = "R5"; // no drivers, pulls in mixed patterns (both set reads high)
        out_en = '0; ext_drive = '0; pull_up = 32'hF0F0_F0F0; pull_dn = 32'hFF00_FF00;
        hold(3);
        tag = "R6";
        pull_up = '0; pull_dn = 32'h0F0F_0F0F;
        hold(3);
        tag = "R7";
        pull_dn = '0;
        hold(3);

        tag = "R8"; // masking and polarity on data-in
        pull_up = 32'h1234_5678; in_en = 32'h0F0F_3333; polarity = 32'h5555_AAAA;
        hold(3);

        tag = "R4"; // random mixed vectors
        for (int k = 0; k < 400; k++) begin
            out_data = $urandom; polarity = $urandom; out_en = $urandom;
            open_drain = $urandom; pull_up = $urandom; pull_dn = $urandom;
            in_en = $urandom; ext_drive = $urandom; ext_level = $urandom;
            hold(1);
        end

        tag = "R9"; // reset mid-run
        rst_n = 1'b0;
        hold(2);
        rst_n = 1'b1;
        hold(2);
        finish_run();
    end

endmodule